// File: doc/BRIEF.md
# Card Data FIFO with Threshold-Driven DMA Requests

This block is the data buffer between a card host controller's register interface and its card-side serial engine. It stores 32 words of 16 bits in a circular buffer. On every cycle it compares the fill level with two programmable watermarks. A nearly full buffer while data flows toward the host, or a nearly drained buffer while data flows toward the card, is reported in one of two ways. If DMA is enabled for that direction, the block raises a DMA request line. If not, it raises a status flag that the surrounding interrupt logic can pick up.

The direction input selects which port fills the buffer and which port drains it. When data moves card-to-host, the card side pushes words and the host side pops them. When data moves host-to-card, the roles are swapped. A small three-state mode machine follows the transfer-active input, the direction input and the fill level. Its states are ST_QUIET (no transfer and nothing buffered), ST_TO_HOST and ST_TO_CARD. Its transitions are:
- begin-to-host: ST_QUIET to ST_TO_HOST.
- begin-to-card: ST_QUIET to ST_TO_CARD.
- turn-around: ST_TO_HOST and ST_TO_CARD to each other.
- settle: any state to ST_QUIET, once the transfer is inactive and the buffer is empty.

All four report outputs are decoded from the registered mode, level and configuration.

Top module: `cardfifo_dma_ctl`

## Requirements
- R1: The buffer holds up to 32 words of 16 bits and returns them in push order. Its read and write positions wrap modulo 32. The word at the read position is always visible on both `host_rdata` and `card_rdata`.
- R2: With `dir_to_host`=1, `card_push` adds `card_wdata` and `host_rd` removes a word. With `dir_to_host`=0, `host_wr` adds `host_wdata` and `card_pop` removes a word. Strobes on the unselected port have no effect.
- R3: A push arriving while 32 words are held is dropped, even if a pop is accepted in the same cycle. The stored words are not changed.
- R4: A pop on an empty buffer leaves both positions unchanged, and the data outputs keep showing the stale word at the read position.
- R5: In the configuration word, bit 15 is the to-host DMA enable, bits 12:8 are the high watermark, bit 7 is the to-card DMA enable and bits 4:0 are the low watermark. Other bits read as zero on `cfg_rdata`. The reset value reads 16'h1F00.
- R6: In ST_TO_HOST, when the level is greater than the high watermark, `rx_dma_req` is 1 if the to-host DMA enable is set; otherwise `flag_af` is 1.
- R7: In ST_TO_CARD, when the level is less than the low watermark, `tx_dma_req` is 1 if the to-card DMA enable is set; otherwise `flag_ae` is 1.
- R8: The cycle after an edge at which `xfer_active` is 0 and the buffer ends up empty, all four report outputs are 0.
- R9: A configuration write that sets a DMA enable clears the matching flag in the first cycle the new word is in effect.
- R10: Outside the condition of R6 or R7, each request and flag is 0, and at most one of the four is high at any time.
- R11: Every report output reflects the push, pop, configuration write, `xfer_active` and `dir_to_host` values seen at the previous rising clock edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | A data transfer is in progress |
| dir_to_host | input | 1 | 1: card-to-host, 0: host-to-card |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host data-port read strobe |
| host_rdata | output | 16 | Word at the read position |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| card_push | input | 1 | Card-side push strobe |
| card_wdata | input | 16 | Card-side push data |
| card_pop | input | 1 | Card-side pop strobe |
| card_rdata | output | 16 | Word at the read position |
| rx_dma_req | output | 1 | To-host DMA request |
| tx_dma_req | output | 1 | To-card DMA request |
| flag_af | output | 1 | High-watermark status flag |
| flag_ae | output | 1 | Low-watermark status flag |

## Verification
A wrong fill count or mode state shows up at the report outputs in the very next cycle, because the requests and flags are decoded directly from registered state. The sweep over every watermark value crosses each threshold one word at a time, so an off-by-one compare changes an output at exactly one level. A pointer fault shows as a wrong word on the data outputs at the first pop that follows. A dropped or duplicated word therefore surfaces within one drain pass.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    localparam int LVL_W    = 5;
    localparam int CFG_W    = 16;
    localparam int RXEN_BIT = 15;
    localparam int HI_LSB   = 8;
    localparam int TXEN_BIT = 7;
    localparam int LO_LSB   = 0;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_TO_HOST = 2'd1,
        ST_TO_CARD = 2'd2
    } mode_e;

    typedef struct packed {
        logic             rx_en;
        logic [LVL_W-1:0] hi_mark;
        logic             tx_en;
        logic [LVL_W-1:0] lo_mark;
    } buf_cfg_t;
endpackage

// File: rtl/cfd_ring.sv
module cfd_ring #(
    parameter int W     = 16,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W:0]   level,
    output logic [LVL_W:0]   level_nxt
);
    localparam int DEPTH = 1 << LVL_W;
    localparam logic [LVL_W:0] FULL = (LVL_W+1)'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [LVL_W-1:0] rd_pos, wr_pos;
    logic             push_ok, pop_ok;

    // push is judged against the level before the edge: a pop in the same
    // cycle does not make room for it
    assign push_ok = push && (level != FULL);
    assign pop_ok  = pop && (level != '0);
    assign head    = mem[rd_pos];

    always_comb begin
        level_nxt = level;
        if (push_ok && !pop_ok) level_nxt = level + 1'b1;
        if (pop_ok && !push_ok) level_nxt = level - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pos <= '0;
            wr_pos <= '0;
            level  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_pos] <= push_data;
                wr_pos      <= wr_pos + 1'b1;
            end
            if (pop_ok) rd_pos <= rd_pos + 1'b1;
            level <= level_nxt;
        end
    end
endmodule

// File: rtl/cfd_cfg_reg.sv
module cfd_cfg_reg
    import cfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output buf_cfg_t         cfg,
    output logic [CFG_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.rx_en   <= 1'b0;
            cfg.hi_mark <= '1;
            cfg.tx_en   <= 1'b0;
            cfg.lo_mark <= '0;
        end else if (wr) begin
            cfg.rx_en   <= wdata[RXEN_BIT];
            cfg.hi_mark <= wdata[HI_LSB +: LVL_W];
            cfg.tx_en   <= wdata[TXEN_BIT];
            cfg.lo_mark <= wdata[LO_LSB +: LVL_W];
        end
    end

    always_comb begin
        rdata                   = '0;
        rdata[RXEN_BIT]         = cfg.rx_en;
        rdata[HI_LSB +: LVL_W]  = cfg.hi_mark;
        rdata[TXEN_BIT]         = cfg.tx_en;
        rdata[LO_LSB +: LVL_W]  = cfg.lo_mark;
    end
endmodule

// File: rtl/cfd_mode_fsm.sv
module cfd_mode_fsm
    import cfd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xfer_active,
    input  logic           dir_to_host,
    input  logic [LVL_W:0] level,
    input  logic [LVL_W:0] level_nxt,
    input  buf_cfg_t       cfg,
    output logic           rx_req,
    output logic           tx_req,
    output logic           hi_flag,
    output logic           lo_flag
);
    mode_e state, state_nxt;
    logic  over_hi, under_lo;

    always_comb begin
        if (!xfer_active && level_nxt == '0) state_nxt = ST_QUIET;   // settle
        else if (dir_to_host)                state_nxt = ST_TO_HOST; // begin-to-host / turn-around
        else                                 state_nxt = ST_TO_CARD; // begin-to-card / turn-around
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nxt;
    end

    assign over_hi  = level > {1'b0, cfg.hi_mark};
    assign under_lo = level < {1'b0, cfg.lo_mark};

    always_comb begin
        rx_req  = 1'b0;
        tx_req  = 1'b0;
        hi_flag = 1'b0;
        lo_flag = 1'b0;
        unique case (state)
            ST_QUIET: ;
            ST_TO_HOST: begin
                rx_req  = over_hi &&  cfg.rx_en;
                hi_flag = over_hi && !cfg.rx_en;
            end
            ST_TO_CARD: begin
                tx_req  = under_lo &&  cfg.tx_en;
                lo_flag = under_lo && !cfg.tx_en;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cardfifo_dma_ctl.sv
module cardfifo_dma_ctl
    import cfd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic             dir_to_host,
    input  logic             host_wr,
    input  logic [W-1:0]     host_wdata,
    input  logic             host_rd,
    output logic [W-1:0]     host_rdata,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             card_push,
    input  logic [W-1:0]     card_wdata,
    input  logic             card_pop,
    output logic [W-1:0]     card_rdata,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             flag_af,
    output logic             flag_ae
);
    logic           push_req, pop_req;
    logic [W-1:0]   push_data, head;
    logic [LVL_W:0] level_q, level_nxt;
    buf_cfg_t       cfg;

    assign push_req  = dir_to_host ? card_push  : host_wr;
    assign push_data = dir_to_host ? card_wdata : host_wdata;
    assign pop_req   = dir_to_host ? host_rd    : card_pop;

    cfd_ring #(.W(W), .LVL_W(LVL_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(push_req), .push_data(push_data), .pop(pop_req),
        .head(head), .level(level_q), .level_nxt(level_nxt)
    );

    cfd_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    cfd_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .xfer_active(xfer_active), .dir_to_host(dir_to_host),
        .level(level_q), .level_nxt(level_nxt), .cfg(cfg),
        .rx_req(rx_dma_req), .tx_req(tx_dma_req),
        .hi_flag(flag_af), .lo_flag(flag_ae)
    );

    assign host_rdata = head;
    assign card_rdata = head;
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker
    import cfd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W:0]   level,
    input logic             push_req,
    input logic             pop_req,
    input logic             xfer_active,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             rx_dma_req,
    input logic             tx_dma_req,
    input logic             flag_af,
    input logic             flag_ae
);
    localparam logic [LVL_W:0] FULL = (LVL_W+1)'(1 << LVL_W);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL && push_req && !pop_req) |=> level == FULL);

    assert_full_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL && push_req && pop_req) |=> level == FULL - 1'b1);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && pop_req && !push_req) |=> level == '0);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && level == '0 && !push_req)
        |=> !(rx_dma_req || tx_dma_req || flag_af || flag_ae));

    assert_rx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[RXEN_BIT]) |=> !flag_af);

    assert_tx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[TXEN_BIT]) |=> !flag_ae);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_dma_req, tx_dma_req, flag_af, flag_ae}));

    assert_rx_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> cfg_rdata[RXEN_BIT]);

    assert_tx_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> cfg_rdata[TXEN_BIT]);
endmodule

bind cardfifo_dma_ctl cfd_checker u_cfd_checker (
    .clk(clk), .rst_n(rst_n), .level(level_q),
    .push_req(push_req), .pop_req(pop_req), .xfer_active(xfer_active),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .flag_af(flag_af), .flag_ae(flag_ae)
);

// File: tb/cardfifo_dma_ctl_bench.sv
`timescale 1ns/1ps
module cardfifo_dma_ctl_bench;
    logic        clk, rst_n, xfer_active, dir_to_host;
    logic        host_wr, host_rd, cfg_wr, card_push, card_pop;
    logic [15:0] host_wdata, cfg_wdata, card_wdata;
    logic [15:0] host_rdata, cfg_rdata, card_rdata;
    logic        rx_dma_req, tx_dma_req, flag_af, flag_ae;

    cardfifo_dma_ctl u_cardfifo_dma_ctl (.*);

    int n_tests = 0, n_fail = 0;
    logic [15:0] m_mem [32];
    int m_rd, m_wr, m_cnt, m_hi, m_lo;
    logic m_rxen, m_txen, m_quiet, m_dir;
    string cur_tag = "R1";

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: model update at the edge, compare in the low phase
    task automatic cyc();
        logic push, pop, pa, po;
        logic [15:0] pd;
        int e;
        @(posedge clk);
        push = dir_to_host ? card_push : host_wr;
        pd   = dir_to_host ? card_wdata : host_wdata;
        pop  = dir_to_host ? host_rd : card_pop;
        pa = push && (m_cnt < 32);
        po = pop && (m_cnt > 0);
        if (pa) begin m_mem[m_wr] = pd; m_wr = (m_wr + 1) % 32; end
        if (po) m_rd = (m_rd + 1) % 32;
        m_cnt = m_cnt + int'(pa) - int'(po);
        if (cfg_wr) begin
            m_rxen = cfg_wdata[15]; m_hi = int'(cfg_wdata[12:8]);
            m_txen = cfg_wdata[7];  m_lo = int'(cfg_wdata[4:0]);
        end
        m_quiet = !xfer_active && (m_cnt == 0);
        m_dir   = dir_to_host;
        @(negedge clk);
        e = 0;
        if (!m_quiet && m_dir && m_cnt > m_hi)  e = m_rxen ? 8 : 2;
        if (!m_quiet && !m_dir && m_cnt < m_lo) e = m_txen ? 4 : 1;
        chk(cur_tag, int'({rx_dma_req, tx_dma_req, flag_af, flag_ae}), e);
        chk("R1 head", int'(host_rdata), int'(m_mem[m_rd]));
        chk("R1 head card", int'(card_rdata), int'(m_mem[m_rd]));
        chk("R5 cfg", int'(cfg_rdata),
            int'({m_rxen, 2'b00, m_hi[4:0], m_txen, 2'b00, m_lo[4:0]}));
        host_wr = 0; host_rd = 0; card_push = 0; card_pop = 0; cfg_wr = 0;
    endtask

    task automatic set_cfg(logic rxen, int hi, logic txen, int lo);
        cfg_wr = 1;
        cfg_wdata = {rxen, 2'b00, 5'(hi), txen, 2'b00, 5'(lo)};
        cyc();
    endtask

    task automatic fill(int n, logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            if (dir_to_host) begin card_push = 1; card_wdata = base + 16'(i); end
            else begin host_wr = 1; host_wdata = base + 16'(i); end
            cyc();
        end
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) begin
            if (dir_to_host) host_rd = 1; else card_pop = 1;
            cyc();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; xfer_active = 0; dir_to_host = 0;
        host_wr = 0; host_rd = 0; cfg_wr = 0; card_push = 0; card_pop = 0;
        host_wdata = 0; cfg_wdata = 0; card_wdata = 0;
        for (int i = 0; i < 32; i++) m_mem[i] = 16'h0;
        m_rd = 0; m_wr = 0; m_cnt = 0; m_hi = 31; m_lo = 0;
        m_rxen = 0; m_txen = 0; m_quiet = 1; m_dir = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        chk("R5 reset cfg", int'(cfg_rdata), 16'h1F00);
        chk("R10 reset outputs", int'({rx_dma_req, tx_dma_req, flag_af, flag_ae}), 0);

        // R5: unused bits read zero
        cur_tag = "R5"; set_cfg(1, 31, 1, 31);
        cfg_wr = 1; cfg_wdata = 16'hFFFF; cyc();
        chk("R5 readback", int'(cfg_rdata), 16'h9F9F);
        set_cfg(0, 31, 0, 0);

        // R4: pop on empty keeps pointers; R2: wrong-port strobes ignored
        cur_tag = "R4"; dir_to_host = 1; xfer_active = 1; cyc();
        host_rd = 1; cyc(); host_rd = 1; cyc();
        cur_tag = "R2"; set_cfg(0, 0, 0, 0);
        host_wr = 1; host_wdata = 16'hDEAD; cyc();
        chk("R2 host_wr ignored to host", int'(flag_af), 0);
        card_pop = 1; cyc();
        fill(3, 16'h0100);
        chk("R2 card push accepted", int'(flag_af), 1);
        // R9: enabling DMA clears the flag in the first cycle it applies
        cur_tag = "R9"; set_cfg(1, 0, 0, 0);
        chk("R9 flag_af cleared", int'(flag_af), 0);
        chk("R9 rx request", int'(rx_dma_req), 1);
        drain(3);

        // R1/R3: order, wrap and full drop in host-to-card direction
        cur_tag = "R3"; dir_to_host = 0; set_cfg(0, 31, 0, 0);
        fill(20, 16'h1000); drain(20);
        fill(33, 16'h2000);
        card_pop = 1; host_wr = 1; host_wdata = 16'hBEEF; cyc();
        chk("R3 full pop with push", int'(card_rdata), 16'h2001);
        host_wr = 1; card_pop = 1; host_wdata = 16'h3000; cyc();
        drain(33);
        cur_tag = "R1"; fill(4, 16'h4000);
        for (int i = 0; i < 8; i++) begin
            host_wr = 1; host_wdata = 16'h5000 + 16'(i); card_pop = 1; cyc();
        end
        drain(5);

        // R6 sweep: every high watermark, both enables
        cur_tag = "R6"; dir_to_host = 1;
        for (int en = 0; en < 2; en++)
            for (int hi = 0; hi < 32; hi++) begin
                set_cfg(1'(en), hi, 0, 0);
                fill(33, 16'(hi * 64)); drain(33);
            end

        // R7 sweep: every low watermark, both enables
        cur_tag = "R7"; dir_to_host = 0;
        for (int en = 0; en < 2; en++)
            for (int lo = 0; lo < 32; lo++) begin
                set_cfg(0, 31, 1'(en), lo);
                fill(33, 16'(lo * 64 + 7)); drain(33);
            end

        // R8: idle and empty forces everything low; idle but holding data does not
        cur_tag = "R8"; set_cfg(0, 31, 0, 20);
        fill(5, 16'h6000); xfer_active = 0; cyc();
        chk("R8 idle with data keeps flag", int'(flag_ae), 1);
        drain(5); cyc();
        chk("R8 idle empty outputs low",
            int'({rx_dma_req, tx_dma_req, flag_af, flag_ae}), 0);
        // R11: one-cycle response to transfer start
        cur_tag = "R11"; xfer_active = 1; cyc();
        chk("R11 flag follows start", int'(flag_ae), 1);
        dir_to_host = 1; cyc();
        chk("R10 turn-around drops flag", int'(flag_ae), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule